// File: doc/BRIEF.md
# Left-Justified Serial Audio Frame Engine

This block produces the timing for a stereo serial audio link from one master clock that runs at 256 times the sample rate. It divides that clock by two to make the bit clock, and it counts 128 bit clocks per frame to make the frame clock. In each frame it sends one 16-bit left word and one 16-bit right word on a serial output, and it collects one left and one right word from a serial input. Each word is MSB first and starts right after a frame-clock edge. All the bit slots that follow the word in each half are driven as zeros.

On the parallel side a valid/ready pair feeds transmit samples in, and a valid/ready pair hands received pairs out. A transmit pair is fetched once per frame, when the left half begins. If no pair is on offer at that moment, the frame is sent as zeros and an underflow pulse is raised. A received pair that the consumer does not accept is dropped, and an overflow pulse is raised. The enable input starts the link at the beginning of a left half. Dropping the enable stops the link and parks every serial line low.

Top module: `lj_audio_frame`

## Requirements
- R1: While enabled, `sclk` is low in the first cycle after the link starts and then toggles on every `clk` cycle, so the bit clock is `clk` divided by two.
- R2: A frame lasts 128 bit clocks. `lrck` is low for 64 of them (the left half) and then high for 64 (the right half). The first frame after enable begins with the left half.
- R3: `lrck` and `sdout` change only together with a falling edge of `sclk`. The one exception is the cycle in which the link starts, when `sdout` presents the first bit while `sclk` is still low.
- R4: In each half, the first 16 bit slots carry the word MSB first: bits 15 down to 0 of `tx_left` in the low half and of `tx_right` in the high half, taken from the pair that was accepted for that frame.
- R5: Bit slots 16 to 63 of each half drive `sdout` low.
- R6: `tx_ready` is high for exactly one `clk` cycle at the start of each frame, one frame (256 `clk` cycles) apart. A pair is accepted when `tx_valid` is high in that cycle.
- R7: If `tx_valid` is low while `tx_ready` is high, `tx_underflow` is high in that same cycle and the whole frame carries zero words. `tx_underflow` is never high at any other time.
- R8: `sdin` is captured at each rising edge of `sclk` in slots 0 to 15 of each half. In the cycle after the last right-word bit is captured, `rx_valid` pulses for one cycle. At that time `rx_left` and `rx_right` hold the words, MSB first.
- R9: If `rx_ready` is low while `rx_valid` is high, the pair is dropped and `rx_overflow` is high in that cycle. `rx_overflow` is never high at any other time.
- R10: With `en` low, `sclk`, `lrck`, `sdout`, `tx_ready` and `rx_valid` are all low from the next cycle on, and the slot counter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Runs the link while high |
| tx_valid | input | 1 | A transmit pair is offered |
| tx_ready | output | 1 | The pair is taken in this cycle |
| tx_left | input | 16 | Left transmit word |
| tx_right | input | 16 | Right transmit word |
| tx_underflow | output | 1 | Pulse: no pair was offered at frame start |
| rx_valid | output | 1 | Pulse: received pair available |
| rx_ready | input | 1 | Consumer accepts the received pair |
| rx_left | output | 16 | Received left word |
| rx_right | output | 16 | Received right word |
| rx_overflow | output | 1 | Pulse: received pair dropped |
| sclk | output | 1 | Bit clock |
| lrck | output | 1 | Frame clock, low for left, high for right |
| sdout | output | 1 | Serial data out |
| sdin | input | 1 | Serial data in |

## Verification
The hardest case to reach is a stop in the middle of a frame, after the left word has gone out but before the right word is complete, followed by a restart that must begin cleanly with a left half. The bench waits for the rising frame-clock edge, lets a few right-half slots pass, and then drops the enable. It checks that the lines are parked low, discards the expectations for the broken frame, and re-enables. It then requires the next decoded word to be a left word that matches the next queued sample. The serial output is looped back to the serial input. Each transmitted pair therefore has to come back intact, which checks bit order and the capture edge from the ports.

// File: rtl/lj_audio_frame.sv
module lj_audio_frame #(
  parameter int SAMPLE_W   = 16,
  parameter int FRAME_BITS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                tx_underflow,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_overflow,
  output logic                sclk,
  output logic                lrck,
  output logic                sdout,
  input  logic                sdin
);
  localparam int CW   = $clog2(FRAME_BITS);
  localparam int HW   = CW - 1;
  localparam int HALF = FRAME_BITS / 2;
  localparam int PW   = 2 * SAMPLE_W;
  localparam int IW   = $clog2(PW);

  logic          run, sclk_q, lrck_q, sdo_q, rxv_q;
  logic [CW-1:0] slot;
  logic [PW-1:0] txw, rxsh, rxpair;

  wire fall = run & sclk_q;
  wire rise = run & ~sclk_q;
  wire adv  = en & (~run | fall);

  wire [CW-1:0] nslot  = run ? slot + 1'b1 : '0;
  wire [HW-1:0] npos   = nslot[HW-1:0];
  wire          nright = nslot[CW-1];
  wire          ndata  = npos < HW'(SAMPLE_W);

  assign tx_ready     = adv & (nslot == '0);
  assign tx_underflow = tx_ready & ~tx_valid;

  wire [PW-1:0] tx_pair = tx_valid ? {tx_left, tx_right} : '0;
  wire [PW-1:0] nword   = tx_ready ? tx_pair : txw;
  wire [IW-1:0] nidx    = IW'((nright ? SAMPLE_W : PW) - 1 - int'(npos));

  wire rx_take = rise & (slot[HW-1:0] < HW'(SAMPLE_W));
  wire rx_last = rise & (slot == CW'(HALF + SAMPLE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      sclk_q <= 1'b0;
      lrck_q <= 1'b0;
      sdo_q  <= 1'b0;
      slot   <= '0;
      txw    <= '0;
      rxsh   <= '0;
      rxv_q  <= 1'b0;
      rxpair <= '0;
    end else if (!en) begin
      run    <= 1'b0;
      sclk_q <= 1'b0;
      lrck_q <= 1'b0;
      sdo_q  <= 1'b0;
      slot   <= '0;
      rxv_q  <= 1'b0;
    end else begin
      rxv_q <= rx_last;
      if (adv) begin
        run    <= 1'b1;
        sclk_q <= 1'b0;
        slot   <= nslot;
        lrck_q <= nright;
        sdo_q  <= ndata & nword[nidx];
        if (tx_ready) txw <= tx_pair;
      end else if (rise) begin
        sclk_q <= 1'b1;
        if (rx_take) rxsh <= {rxsh[PW-2:0], sdin};
      end
      if (rx_last) rxpair <= {rxsh[PW-2:0], sdin};
    end
  end

  assign sclk        = sclk_q;
  assign lrck        = lrck_q;
  assign sdout       = sdo_q;
  assign rx_valid    = rxv_q;
  assign rx_overflow = rxv_q & ~rx_ready;
  assign rx_left     = rxpair[PW-1:SAMPLE_W];
  assign rx_right    = rxpair[SAMPLE_W-1:0];
endmodule

// File: rtl/lj_audio_chk.sv
module lj_audio_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic run,
  input logic sclk,
  input logic lrck,
  input logic sdout,
  input logic tx_ready,
  input logic rx_valid
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !lrck && !sdout && !rx_valid)); // R10

  AST_SCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run) |=> (sclk != $past(sclk))); // R1

  AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(lrck)) |-> $fell(sclk)); // R3

  AST_SDOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(sdout)) |-> ($fell(sclk) || !$past(run))); // R3

  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready); // R6

  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R8
endmodule

bind lj_audio_frame lj_audio_chk u_lj_audio_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .run(run), .sclk(sclk), .lrck(lrck),
  .sdout(sdout), .tx_ready(tx_ready), .rx_valid(rx_valid)
);

// File: tb/test_lj_audio_frame.sv
`timescale 1ns/1ps
module test_lj_audio_frame;
  localparam int W = 16;
  localparam int FB = 128;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b1;
  logic [W-1:0] tx_left = '0, tx_right = '0;
  logic tx_ready, tx_underflow, rx_valid, rx_overflow, sclk, lrck, sdout;
  logic [W-1:0] rx_left, rx_right;

  always #2.5 clk = ~clk;

  lj_audio_frame #(.SAMPLE_W(W), .FRAME_BITS(FB)) i_lj_audio_frame (
    .clk(clk), .rst_n(rst_n), .en(en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_left(tx_left), .tx_right(tx_right), .tx_underflow(tx_underflow),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_left(rx_left), .rx_right(rx_right),
    .rx_overflow(rx_overflow), .sclk(sclk), .lrck(lrck), .sdout(sdout), .sdin(sdout));

  int nchk = 0, nfail = 0;
  int n_uflow = 0, n_oflow = 0, n_rx = 0, n_words = 0;
  logic [2*W-1:0] src_q[$], txexp[$], rxexp[$];
  logic supply = 1'b0, pop_pend = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_src();
    if (supply && src_q.size() != 0) begin
      tx_valid = 1'b1;
      {tx_left, tx_right} = src_q[0];
    end else begin
      tx_valid = 1'b0;
      {tx_left, tx_right} = '0;
    end
  endtask

  int cyc = 0, last_fetch = -1, act_cnt = 0, k = 0;
  logic fresh = 1'b1, half = 1'b0, zbad = 1'b0, prev_sclk = 1'b0, prev_lrck = 1'b0, prev_sdo = 1'b0;
  logic [W-1:0] word = '0, lword = '0;
  logic [2*W-1:0] p;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (pop_pend) begin
      void'(src_q.pop_front());
      pop_pend = 1'b0;
      drive_src();
    end
    // transmit fetch side
    if (tx_ready) begin
      check(tx_underflow == !tx_valid, "R7 underflow flag", 32'(tx_underflow), 32'(!tx_valid));
      if (last_fetch >= 0) check(cyc - last_fetch == 2*FB, "R6 fetch spacing", 32'(cyc - last_fetch), 32'(2*FB));
      last_fetch = cyc;
      if (tx_valid) begin p = {tx_left, tx_right}; pop_pend = 1'b1; end
      else begin p = '0; n_uflow++; end
      txexp.push_back(p);
      rxexp.push_back(p);
    end else if (tx_underflow) check(1'b0, "R7 stray underflow", 1, 0);
    // receive side
    if (rx_valid) begin
      n_rx++;
      p = (rxexp.size() != 0) ? rxexp.pop_front() : 'x;
      if (rx_ready) begin
        check({rx_left, rx_right} === p, "R8 received pair", {rx_left, rx_right}, p);
        check(!rx_overflow, "R9 no overflow when ready", 32'(rx_overflow), 0);
      end else begin
        check(rx_overflow, "R9 overflow on drop", 32'(rx_overflow), 1);
        n_oflow++;
      end
    end else if (rx_overflow) check(1'b0, "R9 stray overflow", 1, 0);
    // serial monitor
    if (!en) begin fresh = 1'b1; act_cnt = 0; end
    else begin
      act_cnt++;
      if (act_cnt >= 3) begin
        check(sclk != prev_sclk, "R1 bit clock toggle", 32'(sclk), 32'(!prev_sclk));
        if (lrck != prev_lrck) check(prev_sclk && !sclk, "R3 lrck on falling sclk", 32'(sclk), 0);
        if (sdout != prev_sdo) check(prev_sclk && !sclk, "R3 sdout on falling sclk", 32'(sclk), 0);
      end
      if (!prev_sclk && sclk) begin
        if (fresh) begin
          fresh = 1'b0; k = 0; half = lrck; zbad = 1'b0;
          check(lrck == 1'b0, "R2 start with left half", 32'(lrck), 0);
        end else if (lrck != half) begin
          check(k == FB/2 - 1, "R2 half length", 32'(k + 1), 32'(FB/2));
          k = 0; half = lrck;
        end else k++;
        if (k < W) word = {word[W-2:0], sdout};
        else if (sdout) zbad = 1'b1;
        if (k == FB/2 - 1) begin
          check(!zbad, "R5 idle slots low", 32'(zbad), 0);
          zbad = 1'b0;
        end
        if (k == W - 1) begin
          if (!half) lword = word;
          else begin
            n_words++;
            p = (txexp.size() != 0) ? txexp.pop_front() : 'x;
            check({lword, word} === p, "R4 serial pair", {lword, word}, p);
          end
        end
      end
    end
    prev_sclk = sclk; prev_lrck = lrck; prev_sdo = sdout;
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic wait_frames(input int n);
    repeat (n * 2 * FB) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!sclk && !lrck && !sdout && !tx_ready && !rx_valid, "R10 reset idle",
          {sclk, lrck, sdout, tx_ready, rx_valid}, 0);
    src_q.push_back({16'h8000, 16'h0001});
    src_q.push_back({16'hFFFF, 16'h0000});
    src_q.push_back({16'hA5A5, 16'h5A5A});
    src_q.push_back({16'h1234, 16'hFEDC});
    @(posedge clk); #1 supply = 1'b1; drive_src(); en = 1'b1;
    wait_frames(7);
    check(n_uflow >= 2, "R7 underflow frames seen", n_uflow, 2);
    // overflow: refuse one received pair
    @(posedge clk); #1 src_q.push_back({16'h0F0F, 16'hC3C3}); src_q.push_back({16'h7001, 16'h800E}); drive_src();
    @(posedge lrck); @(posedge clk); #1 rx_ready = 1'b0;
    wait_frames(1);
    @(posedge clk); #1 rx_ready = 1'b1;
    wait_frames(2);
    check(n_oflow == 1, "R9 one pair dropped", n_oflow, 1);
    // stop in the middle of a right half
    @(posedge lrck); repeat (20) @(posedge clk);
    #1 en = 1'b0;
    @(negedge clk); @(negedge clk);
    txexp.delete(); rxexp.delete();
    for (int i = 0; i < 10; i++) begin
      check(!sclk && !lrck && !sdout && !tx_ready && !rx_valid, "R10 disabled idle",
            {sclk, lrck, sdout, tx_ready, rx_valid}, 0);
      @(negedge clk);
    end
    @(posedge clk); #1
    src_q.push_back({16'h4321, 16'h8765});
    src_q.push_back({16'hDEAD, 16'hBEEF});
    src_q.push_back({16'h0001, 16'h8000});
    drive_src();
    last_fetch = -1;
    en = 1'b1;
    wait_frames(5);
    check(n_words >= 10, "R4 words decoded", n_words, 10);
    check(n_rx >= 10, "R8 pairs received", n_rx, 10);
    finish_run();
  end
endmodule